// File: doc/BRIEF.md
# Multi-Mode Countdown Timer with Watchdog Reset

This block is a 16-bit down-counter behind a small 32-bit register bus. A programmable prescaler slows the count. A two-bit field selects one of four behaviours for the moment the count runs out:
- free-running wrap-around;
- periodic reload from a software-written value;
- a single timeout that switches itself off;
- a watchdog that asks the system for a reset.

Timer events leave as a one-cycle interrupt pulse. A watchdog expiry raises a reset request that lasts a fixed number of clocks. It also sets a sticky cause flag, so software can find out after the reboot why the system restarted.

Two resets are kept apart. `rst` is the power-on reset and clears everything. `soft_rst` is the reset that the system's reset controller applies after a watchdog request. It clears the timer state and leaves the cause flag set. The bus is single-cycle: a write takes effect at the clock edge where `bus_we` is sampled, and read data is registered, so it appears one cycle after the address.

Top module: `cnt16_guard_timer`

## Requirements
- R1: After power-on reset, reads of the load, control and status registers all return 0, and `irq` and `sys_rst_req` are low.
- R2: The load value sits at address 0x00 in bits 15:0. The control register sits at 0x08 with enable in bit 7, mode in bits 5:4 and prescale code in bits 3:0. Control bit 6 and bits 31:8 read as zero, and any address not in the map reads as zero. Read data appears in the cycle after the address is presented.
- R3: Prescale code c divides the clock by 2^c for c = 0..14, and code 15 divides it by 65536. The prescaler phase restarts when enable rises or when the load register is written.
- R4: Writing enable from 0 to 1 reloads the count from the load register. With load L and division D, the first expiry pulses `irq` (L+1)*D clock edges after the enabling write edge.
- R5: While enable is 0 the count holds and no `irq` pulse occurs.
- R6: In mode 1 (periodic), each expiry reloads from the load register and pulses `irq`, so pulses repeat every (L+1)*D clocks.
- R7: In mode 0 (free-running), the count wraps from 0 to 0xFFFF, so expiries after the first are 65536*D clocks apart.
- R8: In mode 2 (one-shot), the expiry pulses `irq` once and clears the enable bit, which then reads back as 0.
- R9: In mode 3 (watchdog), expiry produces no `irq`. It drives `sys_rst_req` high for exactly 16 consecutive clocks. Each write to the load register reloads the count at once, so regular writes prevent expiry.
- R10: Status bit 1 at address 0x38 becomes 1 on watchdog expiry and stays 1 through `soft_rst`. Writing 1 to that bit clears it, and so does power-on reset.
- R11: A load write while counting reloads the count in every mode and restarts the prescaler phase, so the next expiry comes (L+1)*D clocks after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on reset, synchronous, active high; clears all state |
| soft_rst | input | 1 | System reset, synchronous, active high; clears timer state but not the cause flag |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| irq | output | 1 | One-cycle timer event pulse (modes 0 to 2) |
| sys_rst_req | output | 1 | Watchdog reset request, 16 clocks long |

## Verification
The count and the prescaler phase cannot be read, so a wrong internal value shows up only through event timing. A count or phase that is off by one moves the `irq` or `sys_rst_req` edge by one or more clocks at the next expiry. That is at most (L+1)*D cycles after the last reload, and the per-clock reference comparison reports it on that edge. Control and cause state that is wrong shows at the registered read port one cycle after its address is presented. The bench reads these registers back right after every event that could change them: a one-shot self-stop, a watchdog expiry, a soft reset, and a write-one-to-clear.

// File: rtl/tg_pkg.sv
package tg_pkg;

  typedef enum logic [1:0] {
    MD_FREE     = 2'd0,
    MD_PERIODIC = 2'd1,
    MD_ONESHOT  = 2'd2,
    MD_GUARD    = 2'd3
  } tmode_e;

  localparam int OFS_LOAD = 'h00;
  localparam int OFS_CTRL = 'h08;
  localparam int OFS_STAT = 'h38;

  localparam int CTL_EN_BIT    = 7;
  localparam int CTL_MODE_LSB  = 4;
  localparam int STAT_CAUSE_BIT = 1;

endpackage

// File: rtl/tg_prescale.sv
module tg_prescale #(
  parameter int DIV_W  = 16,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              en,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  logic [DIV_W-1:0] ph_q;
  logic [DIV_W-1:0] mask;

  // Top code selects full-width division; lower codes select 2^code.
  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (code == {CODE_W{1'b1}}) || (int'(code) > i);
    end
  end

  assign tick = en && ((ph_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (clr || restart || !en || tick) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  // R3: with a division above one, two ticks are never back to back.
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (clr)
    (tick && mask != '0 && !restart) |=> (!tick || mask == '0));

endmodule

// File: rtl/tg_regs.sv
module tg_regs
  import tg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              por,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  load_q,
  output logic              en_q,
  output tmode_e            mode_q,
  output logic [CODE_W-1:0] code_q,
  output logic              reload_now,
  output logic [CNT_W-1:0]  reload_val,
  input  logic              stop_req,
  input  logic              guard_fire,
  output logic              cause_q
);

  localparam int CTL_USED = CTL_EN_BIT + 1;

  logic wr_load, wr_ctrl, wr_stat, en_rise;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^wdata;

  assign wr_load = we && (addr == ADDR_W'(OFS_LOAD));
  assign wr_ctrl = we && (addr == ADDR_W'(OFS_CTRL));
  assign wr_stat = we && (addr == ADDR_W'(OFS_STAT));
  assign en_rise = wr_ctrl && wdata[CTL_EN_BIT] && !en_q;

  assign reload_now = wr_load || en_rise;
  assign reload_val = wr_load ? wdata[CNT_W-1:0] : load_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      load_q <= '0;
    end else if (wr_load) begin
      load_q <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      en_q   <= 1'b0;
      mode_q <= MD_FREE;
      code_q <= '0;
    end else if (wr_ctrl) begin
      en_q   <= wdata[CTL_EN_BIT];
      mode_q <= tmode_e'(wdata[CTL_MODE_LSB +: 2]);
      code_q <= wdata[CODE_W-1:0];
    end else if (stop_req) begin
      en_q   <= 1'b0;
    end
  end

  // Cause flag lives on the power-on reset only.
  always_ff @(posedge clk) begin
    if (por) begin
      cause_q <= 1'b0;
    end else if (guard_fire) begin
      cause_q <= 1'b1;
    end else if (wr_stat && wdata[STAT_CAUSE_BIT]) begin
      cause_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (addr == ADDR_W'(OFS_LOAD)) begin
        rdata[CNT_W-1:0] <= load_q;
      end else if (addr == ADDR_W'(OFS_CTRL)) begin
        rdata[CTL_USED-1:0] <= {en_q, 1'b0, mode_q, code_q};
      end else if (addr == ADDR_W'(OFS_STAT)) begin
        rdata[STAT_CAUSE_BIT] <= cause_q;
      end
    end
  end

  // R10: an expiry always leaves the cause flag set.
  p_cause_set_r10: assert property (@(posedge clk) disable iff (por)
    guard_fire |=> cause_q);

  // R10: only a write-one-to-clear can drop the flag.
  p_cause_hold_r10: assert property (@(posedge clk) disable iff (por)
    (cause_q && !(wr_stat && wdata[STAT_CAUSE_BIT])) |=> cause_q);

  // R8: a self-stop request with no competing control write turns enable off.
  p_self_stop_r8: assert property (@(posedge clk) disable iff (clr)
    (stop_req && !wr_ctrl) |=> !en_q);

endmodule

// File: rtl/tg_core.sv
module tg_core
  import tg_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RST_HOLD = 16
) (
  input  logic             clk,
  input  logic             por,
  input  logic             clr,
  input  logic             tick,
  input  tmode_e           mode,
  input  logic [CNT_W-1:0] load_q,
  input  logic             reload_now,
  input  logic [CNT_W-1:0] reload_val,
  output logic             irq,
  output logic             guard_fire,
  output logic             stop_req,
  output logic             sys_rst_req
);

  localparam int HOLD_W = $clog2(RST_HOLD + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [HOLD_W-1:0] hold_q;
  logic              expire;

  assign expire     = tick && !clr && (cnt_q == '0) && !reload_now;
  assign guard_fire = expire && (mode == MD_GUARD);
  assign stop_req   = expire && ((mode == MD_ONESHOT) || (mode == MD_GUARD));

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= '0;
    end else if (reload_now) begin
      cnt_q <= reload_val;
    end else if (tick) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        case (mode)
          MD_FREE:     cnt_q <= '1;
          MD_PERIODIC: cnt_q <= load_q;
          default:     cnt_q <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      irq <= 1'b0;
    end else begin
      irq <= expire && (mode != MD_GUARD);
    end
  end

  // Reset request runs on the power-on reset so it completes through soft_rst.
  always_ff @(posedge clk) begin
    if (por) begin
      hold_q      <= '0;
      sys_rst_req <= 1'b0;
    end else if (guard_fire) begin
      hold_q      <= HOLD_W'(RST_HOLD);
      sys_rst_req <= 1'b1;
    end else begin
      sys_rst_req <= (hold_q > HOLD_W'(1));
      if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end
    end
  end

  // R11: a reload always lands in the count on the next edge.
  p_reload_lands_r11: assert property (@(posedge clk) disable iff (clr)
    reload_now |=> (cnt_q == $past(reload_val)));

  // R9: the reset request starts only from a watchdog expiry.
  p_req_origin_r9: assert property (@(posedge clk) disable iff (por)
    $rose(sys_rst_req) |-> $past(guard_fire));

  // R5: an interrupt pulse always follows a prescaler tick.
  p_irq_after_tick_r5: assert property (@(posedge clk) disable iff (clr)
    irq |-> $past(tick));

  // R9: watchdog mode never raises the timer interrupt.
  p_guard_quiet_r9: assert property (@(posedge clk) disable iff (clr)
    guard_fire |=> !irq);

endmodule

// File: rtl/cnt16_guard_timer.sv
module cnt16_guard_timer
  import tg_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  parameter int CODE_W   = 4,
  parameter int DIV_W    = 16,
  parameter int RST_HOLD = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sys_rst_req
);

  logic             clr;
  logic [CNT_W-1:0] load_q, reload_val;
  logic             en_q, reload_now, stop_req, guard_fire, cause_q, tick;
  tmode_e           mode_q;
  logic [CODE_W-1:0] code_q;

  assign clr = rst || soft_rst;

  tg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CODE_W(CODE_W)
  ) i_regs (
    .clk(clk), .por(rst), .clr(clr),
    .addr(bus_addr), .we(bus_we), .wdata(bus_wdata), .rdata(bus_rdata),
    .load_q(load_q), .en_q(en_q), .mode_q(mode_q), .code_q(code_q),
    .reload_now(reload_now), .reload_val(reload_val),
    .stop_req(stop_req), .guard_fire(guard_fire), .cause_q(cause_q)
  );

  tg_prescale #(
    .DIV_W(DIV_W), .CODE_W(CODE_W)
  ) i_prescale (
    .clk(clk), .clr(clr), .en(en_q), .restart(reload_now),
    .code(code_q), .tick(tick)
  );

  tg_core #(
    .CNT_W(CNT_W), .RST_HOLD(RST_HOLD)
  ) i_core (
    .clk(clk), .por(rst), .clr(clr), .tick(tick), .mode(mode_q),
    .load_q(load_q), .reload_now(reload_now), .reload_val(reload_val),
    .irq(irq), .guard_fire(guard_fire), .stop_req(stop_req),
    .sys_rst_req(sys_rst_req)
  );

  // R9/R10: the cause flag is set whenever a reset request begins.
  p_cause_with_req_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_req) |-> cause_q);

endmodule

// File: tb/test_cnt16_guard_timer.sv
module test_cnt16_guard_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, sys_rst_req;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit started = 0;

  always #4 clk = ~clk;

  cnt16_guard_timer i_cnt16_guard_timer (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .sys_rst_req(sys_rst_req)
  );

  // Behavioural reference model, advanced on each rising edge.
  int          m_load, m_cnt, m_phase, m_mode, m_code, m_left;
  bit          m_en, m_irq, m_cause;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    int  d, nxt_rd;
    bit  wl, wc, ws, rise, tk, ex;
    if (rst) begin
      m_load = 0; m_cnt = 0; m_phase = 0; m_mode = 0; m_code = 0;
      m_left = 0; m_en = 0; m_irq = 0; m_cause = 0; m_rdata = 0;
    end else begin
      d    = (m_code == 15) ? 65536 : (1 << m_code);
      wl   = bus_we && bus_addr == 8'h00;
      wc   = bus_we && bus_addr == 8'h08;
      ws   = bus_we && bus_addr == 8'h38;
      rise = wc && bus_wdata[7] && !m_en;
      tk   = m_en && (m_phase == d - 1);
      ex   = tk && m_cnt == 0 && !wl && !rise && !soft_rst;
      case (bus_addr)
        8'h00:   nxt_rd = m_load;
        8'h08:   nxt_rd = (int'(m_en) * 128) + m_mode * 16 + m_code;
        8'h38:   nxt_rd = int'(m_cause) * 2;
        default: nxt_rd = 0;
      endcase
      if (ex && m_mode == 3) m_left = 16;
      else if (m_left > 0) m_left--;
      if (ex && m_mode == 3) m_cause = 1;
      else if (ws && bus_wdata[1]) m_cause = 0;
      if (soft_rst) begin
        m_load = 0; m_cnt = 0; m_phase = 0; m_mode = 0; m_code = 0;
        m_en = 0; m_irq = 0; m_rdata = 0;
      end else begin
        m_rdata = nxt_rd;
        m_irq = ex && m_mode != 3;
        if (wl || rise) begin
          m_cnt = wl ? int'(bus_wdata[15:0]) : m_load;
          m_phase = 0;
        end else if (tk) begin
          m_phase = 0;
          if (m_cnt > 0) m_cnt--;
          else if (m_mode == 0) m_cnt = 65535;
          else if (m_mode == 1) m_cnt = m_load;
        end else if (m_en) m_phase++;
        else m_phase = 0;
        if (wl) m_load = int'(bus_wdata[15:0]);
        if (wc) begin
          m_en = bus_wdata[7]; m_mode = int'(bus_wdata[5:4]); m_code = int'(bus_wdata[3:0]);
        end else if (ex && m_mode >= 2) m_en = 0;
      end
    end
    started = 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare the design with the model on every cycle, away from the edge.
  always @(negedge clk) begin
    if (started && !rst) begin
      check(irq == m_irq, tag, "irq vs model", irq, m_irq);
      check(sys_rst_req == (m_left > 0), tag, "sys_rst_req vs model", sys_rst_req, m_left > 0);
      check(bus_rdata == m_rdata, tag, "rdata vs model", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    check(bus_rdata == exp, req, "register read", bus_rdata, exp);
  endtask

  task automatic wait_irq(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (irq) break;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tag = "R1";
    check(irq == 0 && sys_rst_req == 0, "R1", "outputs after reset", {irq, sys_rst_req}, 0);
    rd(8'h00, 0, "R1"); rd(8'h08, 0, "R1"); rd(8'h38, 0, "R1");

    tag = "R2";
    wr(8'h00, 32'hFFFF_1234);
    rd(8'h00, 32'h1234, "R2");
    wr(8'h08, 32'hFFFF_FF7F);
    rd(8'h08, 32'h3F, "R2");
    rd(8'h10, 0, "R2");

    tag = "R4";
    wr(8'h00, 5);
    wr(8'h08, 32'hA0);
    wait_irq(100, n);
    check(n == 6, "R4", "cycles to first expiry, div 1", n, 6);
    rd(8'h08, 32'h20, "R8");

    tag = "R3";
    wr(8'h00, 2);
    wr(8'h08, 32'hA3);
    wait_irq(200, n);
    check(n == 24, "R3", "cycles to expiry, div 8", n, 24);
    wr(8'h00, 0);
    wr(8'h08, 32'hAF);
    wait_irq(70000, n);
    check(n == 65536, "R3", "cycles to expiry, code 15", n, 65536);

    tag = "R6";
    wr(8'h00, 3);
    wr(8'h08, 32'h91);
    wait_irq(100, n);
    check(n == 8, "R6", "periodic first", n, 8);
    wait_irq(100, n);
    check(n == 8, "R6", "periodic interval", n, 8);
    tag = "R11";
    repeat (3) @(negedge clk);
    wr(8'h00, 1);
    wait_irq(100, n);
    check(n == 4, "R11", "expiry after reload write", n, 4);
    wait_irq(100, n);
    check(n == 4, "R6", "periodic with new load", n, 4);

    tag = "R5";
    wr(8'h08, 32'h11);
    wait_irq(40, n);
    check(n == 40 && !irq, "R5", "no irq while disabled", n, 40);

    tag = "R7";
    wr(8'h00, 1);
    wr(8'h08, 32'h80);
    wait_irq(100, n);
    check(n == 2, "R7", "free-run first expiry", n, 2);
    wait_irq(70000, n);
    check(n == 65536, "R7", "free-run wrap interval", n, 65536);
    wr(8'h08, 32'h00);

    tag = "R9";
    wr(8'h00, 20);
    wr(8'h08, 32'hB2);
    for (int k = 0; k < 5; k++) begin
      repeat (50) @(negedge clk);
      wr(8'h00, 20);
    end
    check(!sys_rst_req, "R9", "keepalive prevents expiry", sys_rst_req, 0);
    n = 0;
    while (!sys_rst_req && n < 200) begin @(negedge clk); n++; end
    check(sys_rst_req, "R9", "expiry requests reset", sys_rst_req, 1);
    n = 0;
    while (sys_rst_req && n < 100) begin @(negedge clk); n++; end
    check(n == 16, "R9", "reset request length", n, 16);
    tag = "R10";
    soft_rst = 1'b1;
    repeat (3) @(negedge clk);
    soft_rst = 1'b0;
    rd(8'h38, 32'h2, "R10");
    rd(8'h08, 32'h0, "R10");
    wr(8'h38, 32'h2);
    rd(8'h38, 32'h0, "R10");
    wr(8'h00, 3);
    wr(8'h08, 32'hB0);
    repeat (30) @(negedge clk);
    rd(8'h38, 32'h2, "R10");
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(8'h38, 32'h0, "R10");

    repeat (20) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule